// File: doc/BRIEF.md
# Segmented Bus to Beat Serializer

This block takes one cycle of a wide, segmented transmit bus and emits its contents as a stream of single-segment beats. Each input segment is 128 bits wide and has its own enable, start-of-packet, end-of-packet, channel, 4-bit empty-byte count and error flag. After capture, the enabled segments come out one per output beat, lowest segment index first.

Each output beat carries the 128-bit word with a 16-bit byte-keep mask, start and end flags, the channel and an error flag. Bytes are big-endian within a word: the first byte of the word sits on bits [127:120]. The empty count of an end segment becomes the keep mask. An error on an end segment overrides the low bits of that count. The block lowers its input ready while segments of the captured cycle are still waiting, so an upstream source can post a whole bus cycle and move on.

Top module: `ssz_serializer`

## Requirements
- R1: While reset is asserted and right after it, `out_vld` is 0 and `in_rdy` is 1.
- R2: When `in_rdy` is 1 and at least one bit of `in_en` is 1 at a rising edge, the cycle is captured and `out_vld` is 1 from the next cycle. A cycle with `in_en` all zero captures nothing.
- R3: Captured segments whose enable is 1 are emitted one per accepted beat in ascending index order, and segments whose enable is 0 are skipped. Segment i occupies `in_data[128*i +: 128]`, `in_chan[CHAN_W*i +: CHAN_W]` and `in_mty[4*i +: 4]`, and its data, start flag and channel appear unchanged on the output.
- R4: A beat whose end flag is 0 has `out_keep` = 16'hFFFF, whatever its empty count.
- R5: A beat whose end flag is 1 and error flag is 0, with empty count k, has `out_keep` = 16'hFFFF << k. Bit 15 of the mask covers data bits [127:120] and bit 0 covers bits [7:0].
- R6: A beat whose end and error flags are both 1 uses an effective count of {mty[3],3'b000}, so its mask is 16'hFF00 when mty[3] is 1 and 16'hFFFF otherwise.
- R7: `out_eop` follows the segment's end flag, and `out_err` is 1 only on a beat whose end flag and error flag are both 1.
- R8: While `out_vld` is 1 and `out_rdy` is 0, the beat on the output stays unchanged in the next cycle.
- R9: `in_rdy` is 0 while any captured segment is still waiting. Inputs presented during that time have no effect. `in_rdy` returns to 1 in the cycle after the last beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_en | input | NSEG | Per-segment enable |
| in_sop | input | NSEG | Per-segment start of packet |
| in_eop | input | NSEG | Per-segment end of packet |
| in_err | input | NSEG | Per-segment error, meaningful with end |
| in_mty | input | 4*NSEG | Per-segment empty byte count |
| in_chan | input | CHAN_W*NSEG | Per-segment channel |
| in_data | input | 128*NSEG | Per-segment data, big-endian bytes |
| in_rdy | output | 1 | Ready to capture a new bus cycle |
| out_vld | output | 1 | Output beat valid |
| out_rdy | input | 1 | Downstream accepts the beat |
| out_data | output | 128 | Beat data |
| out_keep | output | 16 | Byte keep mask, bit 15 for bits [127:120] |
| out_sop | output | 1 | Beat starts a packet |
| out_eop | output | 1 | Beat ends a packet |
| out_err | output | 1 | Packet in error, on end beat only |
| out_chan | output | CHAN_W | Beat channel |

## Verification
Two cases can fall in the same cycle. In the first, a beat is stalled by downstream back-pressure while new input is presented and must be ignored. In the second, the error override and the empty-count mask land on the same end beat. The bench provokes the first on every transfer: it keeps garbage with all enables high on the input during the drain, and it stalls every third beat with a fixed `out_rdy` pattern. Every beat is then compared with arithmetic expectations, both while it is held and when it is accepted. The second case is covered by sweeping all sixteen empty counts with error both set and clear. The error flag and a nonzero count are also placed on segments that are not the end, where both must have no effect.

// File: rtl/ssz_pkg.sv
package ssz_pkg;
  localparam int SEG_W   = 128;
  localparam int SEG_B   = SEG_W / 8;
  localparam int MTY_W   = $clog2(SEG_B);

  typedef struct packed {
    logic [SEG_W-1:0] data;
    logic             sop;
    logic             eop;
    logic             err;
    logic [MTY_W-1:0] mty;
  } seg_t;
endpackage

// File: rtl/ssz_keep_gen.sv
module ssz_keep_gen
  import ssz_pkg::*;
(
  input  logic             eop,
  input  logic             err,
  input  logic [MTY_W-1:0] mty,
  output logic [SEG_B-1:0] keep
);
  logic [MTY_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    if (eop) begin
      if (err) cnt = {mty[MTY_W-1], {(MTY_W-1){1'b0}}};
      else     cnt = mty;
    end
    keep = {SEG_B{1'b1}} << cnt;
  end
endmodule

// File: rtl/ssz_pick.sv
module ssz_pick #(
  parameter int NSEG  = 4,
  parameter int IDX_W = 2
) (
  input  logic [NSEG-1:0]  pend,
  output logic [IDX_W-1:0] idx,
  output logic [NSEG-1:0]  sel_oh
);
  always_comb begin
    idx = '0;
    for (int i = NSEG - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
    sel_oh = '0;
    if (|pend) sel_oh[idx] = 1'b1;
  end
endmodule

// File: rtl/ssz_seg_store.sv
module ssz_seg_store
  import ssz_pkg::*;
#(
  parameter int NSEG   = 4,
  parameter int CHAN_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [NSEG-1:0]          d_sop,
  input  logic [NSEG-1:0]          d_eop,
  input  logic [NSEG-1:0]          d_err,
  input  logic [MTY_W*NSEG-1:0]    d_mty,
  input  logic [CHAN_W*NSEG-1:0]   d_chan,
  input  logic [SEG_W*NSEG-1:0]    d_data,
  output seg_t                     q_seg  [NSEG],
  output logic [CHAN_W-1:0]        q_chan [NSEG]
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    seg_t              seg_d;
    logic [CHAN_W-1:0] chan_d;

    always_comb begin
      seg_d      = q_seg[g];
      chan_d     = q_chan[g];
      if (load) begin
        seg_d.data = d_data[SEG_W*g +: SEG_W];
        seg_d.sop  = d_sop[g];
        seg_d.eop  = d_eop[g];
        seg_d.err  = d_err[g];
        seg_d.mty  = d_mty[MTY_W*g +: MTY_W];
        chan_d     = d_chan[CHAN_W*g +: CHAN_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_seg[g]  <= '0;
        q_chan[g] <= '0;
      end else if (load) begin
        q_seg[g]  <= seg_d;
        q_chan[g] <= chan_d;
      end
    end
  end
endmodule

// File: rtl/ssz_serializer.sv
module ssz_serializer
  import ssz_pkg::*;
#(
  parameter int NSEG   = 4,
  parameter int CHAN_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSEG-1:0]         in_en,
  input  logic [NSEG-1:0]         in_sop,
  input  logic [NSEG-1:0]         in_eop,
  input  logic [NSEG-1:0]         in_err,
  input  logic [4*NSEG-1:0]       in_mty,
  input  logic [CHAN_W*NSEG-1:0]  in_chan,
  input  logic [128*NSEG-1:0]     in_data,
  output logic                    in_rdy,
  output logic                    out_vld,
  input  logic                    out_rdy,
  output logic [127:0]            out_data,
  output logic [15:0]             out_keep,
  output logic                    out_sop,
  output logic                    out_eop,
  output logic                    out_err,
  output logic [CHAN_W-1:0]       out_chan
);
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [NSEG-1:0]   pend_q, pend_d;
  logic [NSEG-1:0]   sel_oh;
  logic [IDX_W-1:0]  idx;
  logic              load, take;
  seg_t              seg_q  [NSEG];
  logic [CHAN_W-1:0] chan_q [NSEG];
  seg_t              cur;

  assign in_rdy  = ~|pend_q;
  assign out_vld = |pend_q;
  assign load    = in_rdy & (|in_en);
  assign take    = out_vld & out_rdy;

  ssz_seg_store #(.NSEG(NSEG), .CHAN_W(CHAN_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .d_sop  (in_sop),
    .d_eop  (in_eop),
    .d_err  (in_err),
    .d_mty  (in_mty),
    .d_chan (in_chan),
    .d_data (in_data),
    .q_seg  (seg_q),
    .q_chan (chan_q)
  );

  ssz_pick #(.NSEG(NSEG), .IDX_W(IDX_W)) u_pick (
    .pend   (pend_q),
    .idx    (idx),
    .sel_oh (sel_oh)
  );

  always_comb begin
    pend_d = pend_q;
    if (load)      pend_d = in_en;
    else if (take) pend_d = pend_q & ~sel_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pend_q <= '0;
    else if (load || take)  pend_q <= pend_d;
  end

  assign cur      = seg_q[idx];
  assign out_data = cur.data;
  assign out_sop  = cur.sop;
  assign out_eop  = cur.eop;
  assign out_err  = cur.eop & cur.err;
  assign out_chan = chan_q[idx];

  ssz_keep_gen u_keep (
    .eop  (cur.eop),
    .err  (cur.err),
    .mty  (cur.mty),
    .keep (out_keep)
  );
endmodule

// File: rtl/ssz_serializer_chk.sv
module ssz_serializer_chk #(
  parameter int NSEG   = 4,
  parameter int CHAN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSEG-1:0]   in_en,
  input logic              in_rdy,
  input logic              out_vld,
  input logic              out_rdy,
  input logic [127:0]      out_data,
  input logic [15:0]       out_keep,
  input logic              out_eop,
  input logic              out_err,
  input logic [CHAN_W-1:0] out_chan
);
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdy && (|in_en)) |=> (out_vld && !in_rdy));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_data) && $stable(out_keep)
                               && $stable(out_chan) && $stable(out_eop) && $stable(out_err)));

  a_r5_keep_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_keep[15] && (((~out_keep) & ((~out_keep) + 16'd1)) == 16'd0)));

  a_r4_full_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_eop) |-> (out_keep == 16'hFFFF && !out_err));

  a_r9_ready_return: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_rdy) |-> $past(out_vld && out_rdy));
endmodule

bind ssz_serializer ssz_serializer_chk #(.NSEG(NSEG), .CHAN_W(CHAN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_en    (in_en),
  .in_rdy   (in_rdy),
  .out_vld  (out_vld),
  .out_rdy  (out_rdy),
  .out_data (out_data),
  .out_keep (out_keep),
  .out_eop  (out_eop),
  .out_err  (out_err),
  .out_chan (out_chan)
);

// File: tb/ssz_serializer_test.sv
`timescale 1ns/1ps
module ssz_serializer_test;
  localparam int NSEG = 4;
  localparam int CW   = 6;

  logic                clk;
  logic                rst_n;
  logic [NSEG-1:0]     in_en, in_sop, in_eop, in_err;
  logic [4*NSEG-1:0]   in_mty;
  logic [CW*NSEG-1:0]  in_chan;
  logic [128*NSEG-1:0] in_data;
  logic                in_rdy, out_vld, out_rdy;
  logic [127:0]        out_data;
  logic [15:0]         out_keep;
  logic                out_sop, out_eop, out_err;
  logic [CW-1:0]       out_chan;

  int n_chk;
  int n_bad;
  int gb;
  bit done;

  ssz_serializer #(.NSEG(NSEG), .CHAN_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_sop(in_sop), .in_eop(in_eop),
    .in_err(in_err), .in_mty(in_mty), .in_chan(in_chan), .in_data(in_data),
    .in_rdy(in_rdy), .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data),
    .out_keep(out_keep), .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
    .out_chan(out_chan)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] seg_data(int tag, int s);
    return {32'(tag), 32'(s), 32'hA5A50000 ^ 32'(tag), 32'(tag * 7 + s)};
  endfunction

  function automatic logic [CW-1:0] seg_chan(int tag, int s);
    return CW'((tag + s) % 64);
  endfunction

  task automatic present(int tag, logic [NSEG-1:0] en, logic [NSEG-1:0] eop,
                         logic err, logic [3:0] mty);
    in_en  = en;
    in_eop = eop;
    in_sop = NSEG'(1);
    in_err = err ? '1 : '0;
    for (int s = 0; s < NSEG; s++) begin
      in_data[128*s +: 128] = seg_data(tag, s);
      in_chan[CW*s +: CW]   = seg_chan(tag, s);
      in_mty[4*s +: 4]      = mty;
    end
    @(negedge clk);
    // R9: garbage with all enables high while busy must be ignored
    in_en  = '1;
    in_sop = '1;
    in_eop = '1;
    in_err = '1;
    in_mty = '1;
    in_chan = '1;
    in_data = '1;
  endtask

  task automatic drain(int tag, logic [NSEG-1:0] en, logic [NSEG-1:0] eop,
                       logic err, logic [3:0] mty);
    for (int s = 0; s < NSEG; s++) begin
      if (en[s]) begin
        logic [3:0]  cnt;
        logic [15:0] kexp;
        cnt  = eop[s] ? (err ? (mty & 4'h8) : mty) : 4'h0;
        kexp = 16'hFFFF << cnt;
        while (1) begin
          bit r;
          r = (gb % 3) != 2;
          gb++;
          out_rdy = r;
          chk("R2", "out_vld", 128'(out_vld), 128'd1);
          chk("R9", "in_rdy busy", 128'(in_rdy), 128'd0);
          chk("R3", "data", out_data, seg_data(tag, s));
          chk("R3", "sop", 128'(out_sop), 128'(s == 0));
          chk("R3", "chan", 128'(out_chan), 128'(seg_chan(tag, s)));
          if (eop[s]) begin
            if (err) chk("R6", "keep err", 128'(out_keep), 128'(kexp));
            else     chk("R5", "keep", 128'(out_keep), 128'(kexp));
          end else begin
            chk("R4", "keep mid", 128'(out_keep), 128'(kexp));
          end
          chk("R7", "eop", 128'(out_eop), 128'(eop[s]));
          chk("R7", "err", 128'(out_err), 128'(err & eop[s]));
          @(negedge clk);
          if (r) break;
          else chk("R8", "held data", out_data, seg_data(tag, s));
        end
      end
    end
    chk("R9", "vld after drain", 128'(out_vld), 128'd0);
    chk("R9", "in_rdy back", 128'(in_rdy), 128'd1);
    in_en = '0;
  endtask

  task automatic xfer(int tag, logic [NSEG-1:0] en, logic [NSEG-1:0] eop,
                      logic err, logic [3:0] mty);
    present(tag, en, eop, err, mty);
    drain(tag, en, eop, err, mty);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; gb = 0; done = 1'b0;
    rst_n = 1'b0; out_rdy = 1'b1;
    in_en = '0; in_sop = '0; in_eop = '0; in_err = '0;
    in_mty = '0; in_chan = '0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "vld in reset", 128'(out_vld), 128'd0);
    chk("R1", "rdy in reset", 128'(in_rdy), 128'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "vld after reset", 128'(out_vld), 128'd0);
    chk("R1", "rdy after reset", 128'(in_rdy), 128'd1);

    // R2: an all-zero enable cycle captures nothing
    in_data = '1; in_eop = '1;
    repeat (2) @(negedge clk);
    chk("R2", "idle vld", 128'(out_vld), 128'd0);
    chk("R2", "idle rdy", 128'(in_rdy), 128'd1);

    // sweep: segment count, empty count, error flag
    for (int n = 1; n <= NSEG; n++) begin
      for (int m = 0; m < 16; m++) begin
        for (int e = 0; e < 2; e++) begin
          logic [NSEG-1:0] en;
          en = NSEG'((1 << n) - 1);
          xfer(n * 100 + m * 2 + e, en, NSEG'(1 << (n - 1)), 1'(e), 4'(m));
        end
      end
    end

    // R3: gaps in the enables are skipped
    xfer(900, 4'b1010, 4'b1000, 1'b0, 4'd5);
    xfer(901, 4'b0101, 4'b0100, 1'b1, 4'd12);
    // several end segments in one cycle
    for (int m = 0; m < 16; m++) begin
      xfer(950 + m, 4'b1111, 4'b0101, 1'(m & 1), 4'(m));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule